// File: doc/BRIEF.md
# Serial Status Write Controller

This block is the command front end of a serial memory that owns a write-enable latch and a protection lock bit. It listens on a mode-0, MSB-first serial slave link made of a chip select, a serial clock and a data input. All three are oversampled by the system clock through two-flop synchronizers, and so is an active-low write-protect pin. Two commands are recognised. The write-enable command (0x06) arms the latch. The status-write command (0x01), followed by one data byte, may change the lock bit and may request a global protect or global unprotect of the memory array.

Nothing is committed while bits are still arriving. The decision is taken at the moment chip select returns high. At that point the controller checks four things: the framing (whole bytes only, data byte complete), the armed latch, the protect pin and the lock value from before the command. It then updates the lock bit, clears the latch and, when the rules allow, issues a single-cycle protect or unprotect request to the array controller.

The control state machine has six states:
- `ST_IDLE`: chip select is high.
- `ST_OPC`: the first byte is being received.
- `ST_WRSR_DATA`: a status-write opcode was seen and the data byte is awaited.
- `ST_WRSR_TAIL`: the data byte has been captured, and later bytes are discarded.
- `ST_WREN_TAIL`: a write-enable opcode was seen.
- `ST_SKIP`: any other opcode was seen.

The transitions are:
- `ST_IDLE` to `ST_OPC` when chip select falls.
- `ST_OPC` to one of the three opcode states when the first byte completes.
- `ST_WRSR_DATA` to `ST_WRSR_TAIL` when the data byte completes.
- Any state back to `ST_IDLE` when chip select rises. This is also the commit point.

Top module: `stsreg_wr_ctrl`

## Requirements
- R1: After reset the lock bit and the write-enable latch read 0 and neither request pulse is high.
- R2: A frame carrying opcode 0x06 sets the write-enable latch when chip select rises on a whole-byte boundary. A frame of 0x06 that ends mid-byte leaves the latch unchanged.
- R3: A status-write frame (opcode 0x01) issued while the latch is 0 leaves the lock bit unchanged and raises no request.
- R4: Bit 7 of the data byte becomes the new lock bit. The lock bit changes only in the cycle after a chip-select rise.
- R5: Bits 5..2 of the data byte form the global code. 4'b1111 yields a one-cycle protect pulse. 4'b0000 yields a one-cycle unprotect pulse. Any other value yields no pulse. The two pulses are never high together.
- R6: Both requests are suppressed when the lock bit was 1 before the command.
- R7: A status-write frame that ends before the eight data bits are complete, or at a total bit count that is not a multiple of 8, aborts. The lock bit is unchanged, no pulse is issued, and the latch is cleared.
- R8: Whole bytes sent after the data byte have no effect on the outcome.
- R9: While write-protect is asserted (pin low), a data byte with bit 7 equal to 0 is ignored entirely and the latch is cleared. A data byte with bit 7 equal to 1 is applied normally.
- R10: The latch reads 0 after every status-write frame, whatever its outcome.
- R11: A frame with any other opcode changes neither the lock bit nor the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, data sampled on its rising edge |
| si | input | 1 | Serial data in, MSB first |
| wp_n | input | 1 | Write-protect pin, active low |
| lock_o | output | 1 | Protection lock bit |
| wel_o | output | 1 | Write-enable latch |
| gprot_o | output | 1 | One-cycle global protect request |
| gunprot_o | output | 1 | One-cycle global unprotect request |

## Verification
The assertions assume that the serial pins move slowly compared with the system clock. Each level of the serial clock, and each gap between chip select and the nearest serial clock edge, must last several system cycles, so that a byte completion never lands in the same cycle as a chip-select rise. They also assume the protect pin is steady around each commit. The stimulus holds every serial half-period for four system cycles and pads the chip-select edges with idle cycles. It changes the protect pin only while chip select is high.

// File: rtl/swc_pkg.sv
package swc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_WRSR_DATA,
        ST_WRSR_TAIL,
        ST_WREN_TAIL,
        ST_SKIP
    } ctl_state_t;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_WEL_SET,
        ACT_WEL_CLR,
        ACT_APPLY
    } commit_t;

endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/swc_shift.sv
module swc_shift #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sck_s,
    input  logic              si_s,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val,
    output logic [CNT_W-1:0]  bit_cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic sck_prev;
    logic sck_rise;

    assign sck_rise = sck_s && !sck_prev && cs_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev  <= 1'b0;
            byte_done <= 1'b0;
            byte_val  <= '0;
            bit_cnt   <= '0;
        end else begin
            sck_prev  <= sck_s;
            byte_done <= 1'b0;
            if (!cs_act) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                byte_val <= {byte_val[BYTE_W-2:0], si_s};
                if (bit_cnt == LAST) begin
                    bit_cnt   <= '0;
                    byte_done <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R7: an idle select always leaves the counter at a byte boundary
    assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (bit_cnt == '0));

    // R8: a completed byte always leaves the counter at the boundary
    assert_done_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> (bit_cnt == '0));
endmodule

// File: rtl/swc_ctrl.sv
module swc_ctrl
    import swc_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter logic [BYTE_W-1:0] OPC_WRSR = 8'h01,
    parameter logic [BYTE_W-1:0] OPC_WREN = 8'h06,
    parameter int LOCK_BIT = 7,
    parameter int CODE_HI  = 5,
    parameter int CODE_LO  = 2,
    localparam int CNT_W   = $clog2(BYTE_W),
    localparam int CODE_W  = CODE_HI - CODE_LO + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              wp_act,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic [CNT_W-1:0]  bit_cnt,
    output logic              lock_o,
    output logic              wel_o,
    output logic              gprot_o,
    output logic              gunprot_o
);
    localparam logic [CODE_W-1:0] CODE_PROT   = '1;
    localparam logic [CODE_W-1:0] CODE_UNPROT = '0;

    ctl_state_t        state, nxt;
    commit_t           act;
    logic              cs_q;
    logic              cs_rise;
    logic              on_boundary;
    logic              lock_new_q;
    logic [CODE_W-1:0] code_q;

    assign cs_rise     = cs_q && !cs_act;
    assign on_boundary = (bit_cnt == '0);

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (cs_act) nxt = ST_OPC;
            ST_OPC: begin
                if (byte_done) begin
                    if (byte_val == OPC_WRSR)      nxt = ST_WRSR_DATA;
                    else if (byte_val == OPC_WREN) nxt = ST_WREN_TAIL;
                    else                           nxt = ST_SKIP;
                end
            end
            ST_WRSR_DATA: if (byte_done) nxt = ST_WRSR_TAIL;
            ST_WRSR_TAIL: nxt = ST_WRSR_TAIL;
            ST_WREN_TAIL: nxt = ST_WREN_TAIL;
            ST_SKIP:      nxt = ST_SKIP;
            default:      nxt = ST_IDLE;
        endcase
        if (cs_rise) nxt = ST_IDLE;
    end

    // commit decision at chip-select release
    always_comb begin
        act = ACT_NONE;
        if (cs_rise) begin
            unique case (state)
                ST_WREN_TAIL: act = on_boundary ? ACT_WEL_SET : ACT_NONE;
                ST_WRSR_DATA: act = ACT_WEL_CLR;
                ST_WRSR_TAIL: begin
                    if (!on_boundary)              act = ACT_WEL_CLR;
                    else if (!wel_o)               act = ACT_WEL_CLR;
                    else if (wp_act && !lock_new_q) act = ACT_WEL_CLR;
                    else                           act = ACT_APPLY;
                end
                default:      act = ACT_NONE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cs_q  <= 1'b0;
        end else begin
            state <= nxt;
            cs_q  <= cs_act;
        end
    end

    // data capture and status outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_new_q <= 1'b0;
            code_q     <= '0;
            lock_o     <= 1'b0;
            wel_o      <= 1'b0;
            gprot_o    <= 1'b0;
            gunprot_o  <= 1'b0;
        end else begin
            gprot_o   <= 1'b0;
            gunprot_o <= 1'b0;
            if (state == ST_WRSR_DATA && byte_done) begin
                lock_new_q <= byte_val[LOCK_BIT];
                code_q     <= byte_val[CODE_HI:CODE_LO];
            end
            unique case (act)
                ACT_WEL_SET: wel_o <= 1'b1;
                ACT_WEL_CLR: wel_o <= 1'b0;
                ACT_APPLY: begin
                    wel_o  <= 1'b0;
                    lock_o <= lock_new_q;
                    if (!lock_o) begin
                        gprot_o   <= (code_q == CODE_PROT);
                        gunprot_o <= (code_q == CODE_UNPROT);
                    end
                end
                default: ;
            endcase
        end
    end

    assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(gprot_o && gunprot_o));

    assert_prior_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gprot_o || gunprot_o) |-> !$past(lock_o));

    assert_lock_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable(lock_o));

    assert_wp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_o) |-> $past(!wp_act));

    assert_wel_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && (state == ST_WRSR_DATA || state == ST_WRSR_TAIL)) |=> !wel_o);

    assert_no_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && state == ST_WRSR_TAIL && !wel_o) |=> ($stable(lock_o) && !gprot_o && !gunprot_o));
endmodule

// File: rtl/stsreg_wr_ctrl.sv
module stsreg_wr_ctrl #(
    parameter int BYTE_W   = 8,
    parameter int SYNC_STG = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic wp_n,
    output logic lock_o,
    output logic wel_o,
    output logic gprot_o,
    output logic gunprot_o
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [3:0]        pins_s;
    logic              cs_act, wp_act, sck_s, si_s;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic [CNT_W-1:0]  bit_cnt;

    // pin order {wp_n, cs_n, sck, si}; idle levels at reset
    swc_sync #(.WIDTH(4), .STAGES(SYNC_STG), .RST_VAL(4'b1100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({wp_n, cs_n, sck, si}),
        .q_o   (pins_s)
    );

    assign wp_act = !pins_s[3];
    assign cs_act = !pins_s[2];
    assign sck_s  = pins_s[1];
    assign si_s   = pins_s[0];

    swc_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sck_s     (sck_s),
        .si_s      (si_s),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .bit_cnt   (bit_cnt)
    );

    swc_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .wp_act    (wp_act),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .bit_cnt   (bit_cnt),
        .lock_o    (lock_o),
        .wel_o     (wel_o),
        .gprot_o   (gprot_o),
        .gunprot_o (gunprot_o)
    );
endmodule

// File: tb/sim_stsreg_wr_ctrl.sv
module sim_stsreg_wr_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
    logic lock_o, wel_o, gprot_o, gunprot_o;

    int checks = 0;
    int fails  = 0;
    int gp_cnt = 0;
    int gu_cnt = 0;

    always #5 clk = ~clk;

    stsreg_wr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n),
        .lock_o(lock_o), .wel_o(wel_o), .gprot_o(gprot_o), .gunprot_o(gunprot_o)
    );

    always @(posedge clk) begin
        if (gprot_o)   gp_cnt <= gp_cnt + 1;
        if (gunprot_o) gu_cnt <= gu_cnt + 1;
    end

    // vector: [15] send write-enable first, [14] protect pin asserted,
    //         [13:8] data-phase bit count, [7:0] data byte
    localparam int NV = 13;
    localparam logic [15:0] VEC [NV] = '{
        {1'b1, 1'b0, 6'd8,  8'h80},  // set lock, code 0000, prior 0 -> unprotect
        {1'b1, 1'b0, 6'd8,  8'h3C},  // clear lock, code 1111, prior 1 -> none
        {1'b1, 1'b0, 6'd8,  8'h3C},  // prior 0 -> protect
        {1'b0, 1'b0, 6'd8,  8'h80},  // latch not armed -> ignored
        {1'b1, 1'b0, 6'd5,  8'h80},  // short data -> abort
        {1'b1, 1'b0, 6'd12, 8'h80},  // mid-byte end -> abort
        {1'b1, 1'b0, 6'd0,  8'h80},  // opcode only -> abort
        {1'b1, 1'b0, 6'd16, 8'h84},  // trailing byte, code 0001
        {1'b1, 1'b1, 6'd8,  8'h3C},  // clear under protect -> ignored
        {1'b1, 1'b1, 6'd8,  8'hBC},  // set under protect, prior 1 -> none
        {1'b1, 1'b0, 6'd8,  8'h00},  // clear, prior 1 -> none
        {1'b1, 1'b1, 6'd8,  8'hBC},  // set under protect, prior 0 -> protect
        {1'b1, 1'b0, 6'd24, 8'h7C}   // two trailing bytes, clear
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // sends the top n bits of f, MSB first
    task automatic frame(input logic [31:0] f, input int n);
        cs_n = 1'b0;
        tick(4);
        for (int i = 0; i < n; i++) begin
            si = f[31-i];
            tick(4);
            sck = 1'b1;
            tick(4);
            sck = 1'b0;
        end
        tick(4);
        cs_n = 1'b1;
        tick(10);
    endtask

    logic m_lock = 1'b0;
    logic m_wel  = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        check("R1 lock", lock_o, 0);
        check("R1 wel", wel_o, 0);
        check("R1 pulses", gprot_o + gunprot_o, 0);
        rst_n = 1'b1;
        tick(3);

        frame({8'h06, 24'h0}, 7);
        check("R2 partial wren", wel_o, 0);
        frame({8'h06, 8'h00, 16'h0}, 11);
        check("R2 mid-byte wren", wel_o, 0);
        frame({8'h06, 24'h0}, 8);
        check("R2 wren", wel_o, 1);
        frame({8'h05, 8'hFF, 16'h0}, 16);
        check("R11 other opcode wel", wel_o, 1);
        check("R11 other opcode lock", lock_o, 0);

        for (int v = 0; v < NV; v++) begin
            automatic logic       wren = VEC[v][15];
            automatic logic       wp   = VEC[v][14];
            automatic int         nb   = int'(VEC[v][13:8]);
            automatic logic [7:0] d    = VEC[v][7:0];
            automatic int         gp0  = gp_cnt;
            automatic int         gu0  = gu_cnt;
            automatic int         egp  = 0;
            automatic int         egu  = 0;
            wp_n = !wp;
            if (wren) begin
                frame({8'h06, 24'h0}, 8);
                m_wel = 1'b1;
            end
            frame({8'h01, d, 8'hA5, 8'h5A}, 8 + nb);
            if (nb >= 8 && (nb % 8) == 0 && m_wel && !(wp && !d[7])) begin
                if (!m_lock && d[5:2] == 4'b1111) egp = 1;
                if (!m_lock && d[5:2] == 4'b0000) egu = 1;
                m_lock = d[7];
            end
            m_wel = 1'b0;
            check($sformatf("R4/R7/R8/R9/R3 lock v%0d", v), lock_o, m_lock);
            check($sformatf("R10 wel v%0d", v), wel_o, m_wel);
            check($sformatf("R5/R6 protect v%0d", v), gp_cnt - gp0, egp);
            check($sformatf("R5/R6 unprotect v%0d", v), gu_cnt - gu0, egu);
            wp_n = 1'b1;
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule